// File: doc/BRIEF.md
# Iterative Quotient Divider

This block is a multi-cycle integer divider that returns only the quotient of one operand by another. The default width is 32 bits. A per-operation flag selects unsigned or two's-complement signed arithmetic. The caller raises `start_i` for one cycle while the block is idle, together with the operands, the signedness flag and a destination register index. The block captures all of these in that cycle, works through one quotient bit per clock with a radix-2 restoring loop, and then pulses `done_o`. In that same cycle it presents the quotient, the destination index and a write-enable for the register file.

The block never traps. A zero divisor is treated as a divisor of one, so the quotient equals the dividend. The one signed case that overflows, the most negative value divided by minus one, is handled the same way and returns the most negative value. When the destination index is zero, the result is still produced but the write-enable stays low, because that register is hard-wired to zero.

Top module: `qdiv_unit`

## Requirements
- R1: With `signed_i` low and a non-zero divisor, `quot_o` at `done_o` equals the unsigned floor of dividend divided by divisor.
- R2: With `signed_i` high and a non-zero divisor, excluding the R4 case, `quot_o` is the two's-complement quotient rounded toward zero. Its sign is the XOR of the operand signs (bit DATA_W-1 of each operand).
- R3: When the divisor is zero, `quot_o` equals the dividend, in both unsigned and signed mode.
- R4: In signed mode, a dividend of only bit DATA_W-1 set divided by all-ones (minus one) yields that same dividend.
- R5: In the `done_o` cycle, `wr_dest_o` carries the captured destination index and `wr_en_o` is high exactly when that index is non-zero. Outside `done_o`, `wr_en_o` is low.
- R6: `start_i` is accepted at a rising edge where `busy_o` is low. `busy_o` is high from the next cycle. `done_o` and the result appear after the DATA_W+2-th rising edge following the accepting edge. `done_o` lasts one cycle, during which `busy_o` is already low.
- R7: `start_i` raised while `busy_o` is high has no effect: the result, its timing and the count of `done_o` pulses are unchanged.
- R8: Operands, signedness and destination are captured at the accepting edge. Later changes on those inputs do not affect the result.
- R9: After a synchronous active-low reset, `busy_o`, `done_o`, `wr_en_o`, `quot_o` and `wr_dest_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request a division; taken only while idle |
| signed_i | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| dividend_i | input | DATA_W | Dividend |
| divisor_i | input | DATA_W | Divisor |
| dest_i | input | IDX_W | Destination register index |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quot_o | output | DATA_W | Quotient, held until the next completion |
| wr_en_o | output | 1 | Register write-enable, valid with `done_o` |
| wr_dest_o | output | IDX_W | Destination index, valid with `done_o` |

## Verification
Every result is due after exactly DATA_W+2 rising edges, counted from the edge that accepts `start_i`. The write-enable and destination index are due in that same cycle. The bench drives stimulus on falling edges and counts the falling edges until `done_o` is seen. It then samples the quotient, the write-enable and the index in that same sample, and checks that the edge count matches DATA_W+2. Operands are scrambled right after acceptance, and extra start pulses are issued mid-operation, so a result taken from live inputs or a restarted operation shows up as a wrong value or a wrong count.

// File: rtl/qdiv_pkg.sv
// Shared types for the iterative quotient divider.
package qdiv_pkg;

    // Sequencer states: idle, operand conditioning, bit iterations, result output
    typedef enum logic [1:0] {
        DIV_IDLE   = 2'd0,
        DIV_PREP   = 2'd1,
        DIV_ITER   = 2'd2,
        DIV_FINISH = 2'd3
    } div_state_e;

endpackage

// File: rtl/qdiv_prep.sv
// Operand conditioning (combinational).
// Turns the captured operands into unsigned magnitudes and a quotient-negate
// flag. A zero divisor, or the signed most-negative / minus-one pair, is
// replaced by a divisor of one, so no trap or overflow case remains.
// Assumes DATA_W >= 2.
module qdiv_prep #(
    parameter int DATA_W = 32
) (
    input  logic              signed_i,
    input  logic [DATA_W-1:0] dividend_i,
    input  logic [DATA_W-1:0] divisor_i,
    output logic [DATA_W-1:0] mag_dvd_o,
    output logic [DATA_W-1:0] mag_dsr_o,
    output logic              neg_quot_o
);
    localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};
    localparam logic [DATA_W-1:0] ONE      = {{(DATA_W-1){1'b0}}, 1'b1};

    logic neg_dvd, neg_dsr, use_one;

    // Derive signs, magnitudes and the substitution decision
    always_comb begin
        neg_dvd   = signed_i & dividend_i[DATA_W-1];
        neg_dsr   = signed_i & divisor_i[DATA_W-1];
        use_one   = (divisor_i == '0) |
                    (signed_i & (dividend_i == MOST_NEG) & (divisor_i == ALL_ONES));
        mag_dvd_o = neg_dvd ? (~dividend_i + ONE) : dividend_i;
        if (use_one) begin
            mag_dsr_o  = ONE;
            neg_quot_o = neg_dvd;
        end else begin
            mag_dsr_o  = neg_dsr ? (~divisor_i + ONE) : divisor_i;
            neg_quot_o = neg_dvd ^ neg_dsr;
        end
    end

endmodule

// File: rtl/qdiv_core.sv
// Radix-2 restoring division datapath.
// load_i takes in the dividend and divisor magnitudes. Each step_i cycle
// shifts one dividend bit into the partial remainder and retires one quotient
// bit. After DATA_W steps, quo_o holds the unsigned quotient.
// Assumes the divisor magnitude is non-zero (guaranteed by qdiv_prep).
module qdiv_core #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic [DATA_W-1:0] dvd_i,
    input  logic [DATA_W-1:0] dsr_i,
    output logic [DATA_W-1:0] quo_o
);
    logic [DATA_W-1:0] rem_q, quo_q, dsr_q;
    logic [DATA_W:0]   shifted;
    logic [DATA_W+1:0] diff;
    logic              fits;

    // Trial subtraction of the divisor from the shifted partial remainder
    always_comb begin
        shifted = {rem_q, quo_q[DATA_W-1]};
        diff    = {1'b0, shifted} - {2'b00, dsr_q};
        fits    = ~diff[DATA_W+1];
    end

    // Remainder, quotient and divisor registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            dsr_q <= '0;
        end else if (load_i) begin
            rem_q <= '0;
            quo_q <= dvd_i;
            dsr_q <= dsr_i;
        end else if (step_i) begin
            rem_q <= fits ? diff[DATA_W-1:0] : shifted[DATA_W-1:0];
            quo_q <= {quo_q[DATA_W-2:0], fits};
        end
    end

    assign quo_o = quo_q;

endmodule

// File: rtl/qdiv_sign.sv
// Result sign fix-up (combinational): negates the magnitude quotient when
// the quotient is negative. Purely combinational, no state.
module qdiv_sign #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] mag_i,
    input  logic              neg_i,
    output logic [DATA_W-1:0] res_o
);
    // Two's-complement negate on demand
    always_comb begin
        res_o = neg_i ? (~mag_i + {{(DATA_W-1){1'b0}}, 1'b1}) : mag_i;
    end

endmodule

// File: rtl/qdiv_unit.sv
// Iterative quotient divider, top level.
// Sequences capture -> prep -> DATA_W iterations -> finish. done_o pulses
// DATA_W+2 edges after the accepting edge. start_i is only taken while idle.
// The write-enable is suppressed for destination index zero.
// Assumes DATA_W >= 2 and a synchronous active-low reset.
module qdiv_unit
    import qdiv_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              signed_i,
    input  logic [DATA_W-1:0] dividend_i,
    input  logic [DATA_W-1:0] divisor_i,
    input  logic [IDX_W-1:0]  dest_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] quot_o,
    output logic              wr_en_o,
    output logic [IDX_W-1:0]  wr_dest_o
);
    localparam int              CNT_W     = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(DATA_W - 1);

    div_state_e        state_q, state_d;
    logic              accept;
    logic              sgn_q;
    logic [DATA_W-1:0] dvd_q, dsr_q;
    logic [IDX_W-1:0]  dest_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              neg_keep_q;
    logic [DATA_W-1:0] mag_dvd, mag_dsr, core_quo, signed_res;
    logic              neg_quot;
    logic              done_q, wr_en_q;
    logic [DATA_W-1:0] quot_q;
    logic [IDX_W-1:0]  wr_dest_q;

    assign accept = (state_q == DIV_IDLE) & start_i;

    // Next-state selection for the sequencer
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DIV_IDLE:   if (start_i) state_d = DIV_PREP;
            DIV_PREP:   state_d = DIV_ITER;
            DIV_ITER:   if (cnt_q == '0) state_d = DIV_FINISH;
            DIV_FINISH: state_d = DIV_IDLE;
            default:    state_d = DIV_IDLE;
        endcase
    end

    // Sequencer state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DIV_IDLE;
        else        state_q <= state_d;
    end

    // Capture the request at the accepting edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sgn_q  <= 1'b0;
            dvd_q  <= '0;
            dsr_q  <= '0;
            dest_q <= '0;
        end else if (accept) begin
            sgn_q  <= signed_i;
            dvd_q  <= dividend_i;
            dsr_q  <= divisor_i;
            dest_q <= dest_i;
        end
    end

    qdiv_prep #(.DATA_W(DATA_W)) prep_i (
        .signed_i   (sgn_q),
        .dividend_i (dvd_q),
        .divisor_i  (dsr_q),
        .mag_dvd_o  (mag_dvd),
        .mag_dsr_o  (mag_dsr),
        .neg_quot_o (neg_quot)
    );

    // Keep the quotient sign and count the remaining iterations
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            neg_keep_q <= 1'b0;
            cnt_q      <= '0;
        end else if (state_q == DIV_PREP) begin
            neg_keep_q <= neg_quot;
            cnt_q      <= LAST_STEP;
        end else if (state_q == DIV_ITER) begin
            cnt_q      <= cnt_q - 1'b1;
        end
    end

    qdiv_core #(.DATA_W(DATA_W)) core_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (state_q == DIV_PREP),
        .step_i (state_q == DIV_ITER),
        .dvd_i  (mag_dvd),
        .dsr_i  (mag_dsr),
        .quo_o  (core_quo)
    );

    qdiv_sign #(.DATA_W(DATA_W)) sign_i (
        .mag_i (core_quo),
        .neg_i (neg_keep_q),
        .res_o (signed_res)
    );

    // Result, completion pulse and register-file write controls
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q    <= 1'b0;
            wr_en_q   <= 1'b0;
            quot_q    <= '0;
            wr_dest_q <= '0;
        end else begin
            done_q  <= (state_q == DIV_FINISH);
            wr_en_q <= (state_q == DIV_FINISH) && (dest_q != '0);
            if (state_q == DIV_FINISH) begin
                quot_q    <= signed_res;
                wr_dest_q <= dest_q;
            end
        end
    end

    assign busy_o    = (state_q != DIV_IDLE);
    assign done_o    = done_q;
    assign quot_o    = quot_q;
    assign wr_en_o   = wr_en_q;
    assign wr_dest_o = wr_dest_q;

endmodule

// File: rtl/qdiv_unit_chk.sv
// Property checker for qdiv_unit; observes ports only and records each
// accepted request itself.
module qdiv_unit_chk #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              signed_i,
    input logic [DATA_W-1:0] dividend_i,
    input logic [DATA_W-1:0] divisor_i,
    input logic [IDX_W-1:0]  dest_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [DATA_W-1:0] quot_o,
    input logic              wr_en_o,
    input logic [IDX_W-1:0]  wr_dest_o
);
    localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

    logic              rec_s;
    logic [DATA_W-1:0] rec_a, rec_b;
    logic [IDX_W-1:0]  rec_d;
    logic [15:0]       lat_q;

    // Record the accepted request and count cycles since acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_s <= 1'b0;
            rec_a <= '0;
            rec_b <= '0;
            rec_d <= '0;
            lat_q <= '0;
        end else if (!busy_o && start_i) begin
            rec_s <= signed_i;
            rec_a <= dividend_i;
            rec_b <= divisor_i;
            rec_d <= dest_i;
            lat_q <= '0;
        end else if (busy_o) begin
            lat_q <= lat_q + 16'd1;
        end
    end

    a_r1_unsigned_quot: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !rec_s && rec_b != '0) |-> (quot_o == rec_a / rec_b));
    a_r3_zero_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && rec_b == '0) |-> (quot_o == rec_a));
    a_r4_most_neg: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && rec_s && rec_a == MOST_NEG && rec_b == '1) |-> (quot_o == MOST_NEG));
    a_r5_wr_gated: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (done_o && wr_dest_o != '0));
    a_r5_wr_dest: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (wr_dest_o == rec_d && wr_en_o == (rec_d != '0)));
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
    a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (lat_q == 16'(DATA_W + 2)));
    a_r7_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o);

endmodule

bind qdiv_unit qdiv_unit_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .signed_i   (signed_i),
    .dividend_i (dividend_i),
    .divisor_i  (divisor_i),
    .dest_i     (dest_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .quot_o     (quot_o),
    .wr_en_o    (wr_en_o),
    .wr_dest_o  (wr_dest_o)
);

// File: tb/qdiv_unit_tb_top.sv
// Exhaustive sweep of a 6-bit divider over both signedness modes.
module qdiv_unit_tb_top;
    localparam int W = 6;
    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         signed_i = 1'b0;
    logic [W-1:0] dividend_i = '0;
    logic [W-1:0] divisor_i = '0;
    logic [4:0]   dest_i = '0;
    logic         busy_o, done_o, wr_en_o;
    logic [W-1:0] quot_o;
    logic [4:0]   wr_dest_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    qdiv_unit #(.DATA_W(W), .IDX_W(5)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
        .dividend_i(dividend_i), .divisor_i(divisor_i), .dest_i(dest_i),
        .busy_o(busy_o), .done_o(done_o), .quot_o(quot_o),
        .wr_en_o(wr_en_o), .wr_dest_o(wr_dest_o)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Quotient expected from the requirements
    function automatic logic [W-1:0] model(input bit s, input logic [W-1:0] a,
                                           input logic [W-1:0] b);
        int sa, sb, q;
        sa = $signed({{(32-W){a[W-1]}}, a});
        sb = $signed({{(32-W){b[W-1]}}, b});
        if (b == '0) return a;                       // R3
        if (!s) return a / b;                        // R1
        if (a == MINV && b == '1) return a;          // R4
        q = sa / sb;                                 // R2: truncation toward zero
        return q[W-1:0];
    endfunction

    // One operation, entered and left on a falling edge
    task automatic do_op(input bit s, input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [4:0] dst, input bit disturb);
        int k;
        logic [W-1:0] exp;
        string tag;
        exp = model(s, a, b);
        tag = (b == '0) ? "R3" : (s && a == MINV && b == '1) ? "R4" : s ? "R2" : "R1";
        start_i = 1'b1; signed_i = s; dividend_i = a; divisor_i = b; dest_i = dst;
        @(posedge clk);
        @(negedge clk);
        // R8: scramble all captured inputs right after acceptance
        start_i = 1'b0; signed_i = ~s; dividend_i = ~a; divisor_i = b + 1'b1; dest_i = ~dst;
        k = 1;
        while (!done_o && k < W + 10) begin
            if (disturb && k == 3) start_i = 1'b1;   // R7: request while busy
            if (k == 4) start_i = 1'b0;
            @(negedge clk);
            k++;
        end
        // k-1 rising edges have passed since the accepting edge
        check((k - 1) == W + 2 && done_o, disturb ? "R7" : "R6", "latency", k - 1, W + 2);
        check(quot_o == exp, tag, "quotient", int'(quot_o), int'(exp));
        check(wr_en_o == (dst != 0) && wr_dest_o == dst, "R5", "write enable/index",
              int'({wr_en_o, wr_dest_o}), int'({(dst != 0), dst}));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: outputs cleared by reset
        check(!busy_o && !done_o && !wr_en_o && quot_o == '0 && wr_dest_o == '0,
              "R9", "reset outputs", int'({busy_o, done_o, wr_en_o, quot_o, wr_dest_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int s = 0; s < 2; s++) begin
            for (int a = 0; a < (1 << W); a++) begin
                for (int b = 0; b < (1 << W); b++) begin
                    do_op(s[0], a[W-1:0], b[W-1:0], 5'((a * 3 + b) % 8), ((a ^ b) & 7) == 5);
                end
            end
        end
        // R7/R6: no further done pulse once idle
        start_i = 1'b0;
        for (int i = 0; i < W + 4; i++) begin
            @(negedge clk);
            check(!done_o && !busy_o && !wr_en_o, "R7", "spurious completion",
                  int'({done_o, busy_o, wr_en_o}), 0);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule